// File: doc/BRIEF.md
# SCAM Initiation Bus Sequencer

This block opens the SCAM selection protocol on a parallel SCSI bus. A single start pulse launches a fixed series of wired-OR moves. BSY is taken first. After a deskew wait the block takes SEL and I/O, and it also takes C/D when configured as a SCAM master. The data bits DB6 and DB7 are then placed in an output latch and their drivers are enabled. After a second deskew wait the block lets SEL go and waits for the bus to show SEL quiet. It then lets DB6 go and reads C/D to find out whether any master is taking part.

When no device holds C/D, every line is released and a no-master flag pulses. When some device holds C/D, the block waits until all devices have dropped DB6 and then takes SEL again. At that point it pulses done and leaves the bus held for the identification phase that follows. Every wait on a released wired-OR line is glitch-filtered: the line must read deasserted on a parameterised number of consecutive clocks. The deskew length is a count of clocks. The count and the master/slave role are both captured when the sequence starts.

Bus signals use positive logic on both sides. An output at 1 turns on that line's open-collector driver. An input at 1 means the resolved bus line is asserted.

Top module: `scam_init_seq`

## Requirements
- R1: While reset is held, all line drives, done, noMaster and busy are 0.
- R2: A start seen at a clock edge while idle makes bsyOut and busy 1 from the next cycle, with every other drive 0. deskewCnt (D) and isMaster are captured at that edge. A start while busy is 1 has no effect on any output.
- R3: BSY is driven alone for W = max(2·D, 1) cycles. selOut and ioOut then rise in the same cycle, and cdOut rises with them if and only if the captured role is master.
- R4: db6Out and db7Out rise together exactly two cycles after selOut rises. The first of these cycles loads the data latch and the second enables the drivers.
- R5: After db6Out/db7Out have been driven for W cycles, selOut falls while bsyOut, ioOut, cdOut, db6Out and db7Out stay as they were.
- R6: Counting starts on the clock after SEL is released. db6Out falls at the first edge at which selIn has been sampled 0 on FILT_N consecutive edges. Any sample of 1 restarts the count.
- R7: One edge after db6Out falls, cdIn is sampled. If it is 0, all drives fall at that edge, noMaster is 1 for exactly one cycle, and busy falls with it.
- R8: If that cdIn sample is 1, db6In is filtered the same way as in R6, with counting starting on the next edge. Once FILT_N consecutive 0 samples are seen, selOut rises again, done is 1 for one cycle and busy falls. bsyOut, ioOut and db7Out stay driven, and cdOut stays driven if the role is master.
- R9: After done, the held lines stay driven until the next accepted start. That start releases every line except BSY.
- R10: done and noMaster are never 1 together, and neither stays 1 for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches the sequence when idle |
| isMaster | input | 1 | 1 = this device acts as a SCAM master (drives C/D) |
| deskewCnt | input | DLY_W | Deskew delay D in clocks |
| selIn | input | 1 | Resolved SEL line, 1 = asserted |
| cdIn | input | 1 | Resolved C/D line, 1 = asserted |
| db6In | input | 1 | Resolved DB6 line, 1 = asserted |
| bsyOut | output | 1 | Drive BSY |
| selOut | output | 1 | Drive SEL |
| ioOut | output | 1 | Drive I/O |
| cdOut | output | 1 | Drive C/D |
| db6Out | output | 1 | Drive DB6 |
| db7Out | output | 1 | Drive DB7 |
| done | output | 1 | One-cycle pulse: initiation completed |
| noMaster | output | 1 | One-cycle pulse: no master present, bus released |
| busy | output | 1 | High from an accepted start until either outcome |

## Verification
All outputs are registered, so every result shows up one cycle after the edge that decides it. BSY follows a start by one cycle. SEL, I/O and C/D appear W edges later, and DB6/DB7 appear two edges after that. SEL is released after another W edges. Each filtered wait ends FILT_N edges after the last asserted sample, and the outcome pulses follow the C/D sample or the DB6 filter by one edge. A behavioural reference walks the same sequence with plain edge counts. It models the other bus devices as bench-driven lines and compares every output at the falling clock edge, midway between the edges at which results change. The stimulus covers deskew counts of 0 to 3, both roles, filter glitches on SEL and DB6, and a start and configuration changes issued mid-run.

// File: rtl/scam_seq_pkg.sv
package scam_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLY1,
    ST_LATCH,
    ST_ENABLE,
    ST_DLY2,
    ST_SELQ,
    ST_CHKCD,
    ST_DB6Q
  } seqState_t;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic startRun;
    logic setArb;
    logic loadLatch;
    logic enDrv;
    logic loadDly;
    logic stepDly;
    logic dropSel;
    logic dropDb6;
    logic clrFilt;
    logic runSelF;
    logic runDb6F;
    logic finishOk;
    logic finishNone;
  } dpCmd_t;

  // status returned by the datapath
  typedef struct packed {
    logic dlyLast;
    logic selQuiet;
    logic db6Quiet;
    logic cdHeld;
  } dpStat_t;

endpackage

// File: rtl/scam_quiet_filt.sv
module scam_quiet_filt #(
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  input  logic lineIn,
  output logic quiet
);
  localparam int FCNT_W = (FILT_N < 2) ? 1 : $clog2(FILT_N);
  localparam logic [FCNT_W-1:0] LAST = FCNT_W'(FILT_N - 1);

  logic [FCNT_W-1:0] lowRun;

  // this sample completes the run of deasserted samples
  assign quiet = !lineIn && (lowRun == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (clr) begin
      lowRun <= '0;
    end else if (run) begin
      if (lineIn) begin
        lowRun <= '0;
      end else if (lowRun != LAST) begin
        lowRun <= lowRun + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scam_dly_cnt.sv
module scam_dly_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DLY_W-1:0] delayVal,
  input  logic             step,
  output logic             last
);
  localparam int CNT_W = DLY_W + 1;

  logic [CNT_W-1:0] remain;

  // exit when one or zero clocks remain, giving max(2D,1) cycles
  assign last = (remain <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (load) begin
      remain <= {delayVal, 1'b0};
    end else if (step && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/scam_seq_ctrl.sv
module scam_seq_ctrl
  import scam_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCmd_t  cmd
);
  seqState_t curState, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    cmd      = '0;
    nxtState = curState;
    unique case (curState)
      ST_IDLE: begin
        if (start) begin
          cmd.startRun = 1'b1;
          nxtState     = ST_DLY1;
        end
      end
      ST_DLY1: begin
        if (stat.dlyLast) begin
          cmd.setArb = 1'b1;
          nxtState   = ST_LATCH;
        end else begin
          cmd.stepDly = 1'b1;
        end
      end
      ST_LATCH: begin
        cmd.loadLatch = 1'b1;
        nxtState      = ST_ENABLE;
      end
      ST_ENABLE: begin
        cmd.enDrv   = 1'b1;
        cmd.loadDly = 1'b1;
        nxtState    = ST_DLY2;
      end
      ST_DLY2: begin
        if (stat.dlyLast) begin
          cmd.dropSel = 1'b1;
          cmd.clrFilt = 1'b1;
          nxtState    = ST_SELQ;
        end else begin
          cmd.stepDly = 1'b1;
        end
      end
      ST_SELQ: begin
        cmd.runSelF = 1'b1;
        if (stat.selQuiet) begin
          cmd.dropDb6 = 1'b1;
          nxtState    = ST_CHKCD;
        end
      end
      ST_CHKCD: begin
        if (stat.cdHeld) begin
          cmd.clrFilt = 1'b1;
          nxtState    = ST_DB6Q;
        end else begin
          cmd.finishNone = 1'b1;
          nxtState       = ST_IDLE;
        end
      end
      ST_DB6Q: begin
        cmd.runDb6F = 1'b1;
        if (stat.db6Quiet) begin
          cmd.finishOk = 1'b1;
          nxtState     = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/scam_seq_dp.sv
module scam_seq_dp
  import scam_seq_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int FILT_N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             isMaster,
  input  logic [DLY_W-1:0] deskewCnt,
  input  logic             selIn,
  input  logic             cdIn,
  input  logic             db6In,
  output dpStat_t          stat,
  output logic             bsyOut,
  output logic             selOut,
  output logic             ioOut,
  output logic             cdOut,
  output logic             db6Out,
  output logic             db7Out,
  output logic             done,
  output logic             noMaster,
  output logic             busy
);
  localparam int LINES = 2;

  logic             bsyR, selR, ioR, cdR;
  logic             db6Latch, db7Latch, drvEn;
  logic             masterR;
  logic [DLY_W-1:0] deskewR;
  logic             doneR, noneR, busyR;
  logic             dlyLast;

  logic [LINES-1:0] watchLine, watchRun, watchQuiet;

  assign watchLine = {db6In, selIn};
  assign watchRun  = {cmd.runDb6F, cmd.runSelF};

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_filt
      scam_quiet_filt #(.FILT_N(FILT_N)) u_filt (
        .clk   (clk),
        .rstN  (rstN),
        .clr   (cmd.clrFilt | cmd.startRun),
        .run   (watchRun[i]),
        .lineIn(watchLine[i]),
        .quiet (watchQuiet[i])
      );
    end
  endgenerate

  scam_dly_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk),
    .rstN    (rstN),
    .load    (cmd.startRun | cmd.loadDly),
    .delayVal(cmd.startRun ? deskewCnt : deskewR),
    .step    (cmd.stepDly),
    .last    (dlyLast)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsyR     <= 1'b0;
      selR     <= 1'b0;
      ioR      <= 1'b0;
      cdR      <= 1'b0;
      db6Latch <= 1'b0;
      db7Latch <= 1'b0;
      drvEn    <= 1'b0;
      masterR  <= 1'b0;
      deskewR  <= '0;
      doneR    <= 1'b0;
      noneR    <= 1'b0;
      busyR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      noneR <= 1'b0;
      if (cmd.startRun) begin
        bsyR     <= 1'b1;
        selR     <= 1'b0;
        ioR      <= 1'b0;
        cdR      <= 1'b0;
        db6Latch <= 1'b0;
        db7Latch <= 1'b0;
        drvEn    <= 1'b0;
        masterR  <= isMaster;
        deskewR  <= deskewCnt;
        busyR    <= 1'b1;
      end
      if (cmd.setArb) begin
        selR <= 1'b1;
        ioR  <= 1'b1;
        cdR  <= masterR;
      end
      if (cmd.loadLatch) begin
        db6Latch <= 1'b1;
        db7Latch <= 1'b1;
      end
      if (cmd.enDrv)   drvEn    <= 1'b1;
      if (cmd.dropSel) selR     <= 1'b0;
      if (cmd.dropDb6) db6Latch <= 1'b0;
      if (cmd.finishNone) begin
        bsyR     <= 1'b0;
        selR     <= 1'b0;
        ioR      <= 1'b0;
        cdR      <= 1'b0;
        db6Latch <= 1'b0;
        db7Latch <= 1'b0;
        drvEn    <= 1'b0;
        noneR    <= 1'b1;
        busyR    <= 1'b0;
      end
      if (cmd.finishOk) begin
        selR  <= 1'b1;
        doneR <= 1'b1;
        busyR <= 1'b0;
      end
    end
  end

  assign stat.dlyLast  = dlyLast;
  assign stat.selQuiet = watchQuiet[0];
  assign stat.db6Quiet = watchQuiet[1];
  assign stat.cdHeld   = cdIn;

  assign bsyOut   = bsyR;
  assign selOut   = selR;
  assign ioOut    = ioR;
  assign cdOut    = cdR;
  assign db6Out   = db6Latch & drvEn;
  assign db7Out   = db7Latch & drvEn;
  assign done     = doneR;
  assign noMaster = noneR;
  assign busy     = busyR;
endmodule

// File: rtl/scam_init_seq.sv
module scam_init_seq
  import scam_seq_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int FILT_N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isMaster,
  input  logic [DLY_W-1:0] deskewCnt,
  input  logic             selIn,
  input  logic             cdIn,
  input  logic             db6In,
  output logic             bsyOut,
  output logic             selOut,
  output logic             ioOut,
  output logic             cdOut,
  output logic             db6Out,
  output logic             db7Out,
  output logic             done,
  output logic             noMaster,
  output logic             busy
);
  dpCmd_t  cmd;
  dpStat_t stat;

  scam_seq_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .cmd  (cmd)
  );

  scam_seq_dp #(.DLY_W(DLY_W), .FILT_N(FILT_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .isMaster (isMaster),
    .deskewCnt(deskewCnt),
    .selIn    (selIn),
    .cdIn     (cdIn),
    .db6In    (db6In),
    .stat     (stat),
    .bsyOut   (bsyOut),
    .selOut   (selOut),
    .ioOut    (ioOut),
    .cdOut    (cdOut),
    .db6Out   (db6Out),
    .db7Out   (db7Out),
    .done     (done),
    .noMaster (noMaster),
    .busy     (busy)
  );
endmodule

// File: rtl/scam_init_seq_chk.sv
module scam_init_seq_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic selIn,
  input logic bsyOut,
  input logic selOut,
  input logic ioOut,
  input logic cdOut,
  input logic db6Out,
  input logic db7Out,
  input logic done,
  input logic noMaster,
  input logic busy
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && bsyOut && !selOut && !db7Out));

  // R3
  cd_with_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cdOut) |-> ($rose(selOut) && ioOut));

  // R4
  data_after_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(db7Out) |-> (selOut && $past(selOut)));

  // R6
  db6_after_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(db6Out) && busy) |-> ($past(!selIn) && !selOut));

  // R7
  none_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    noMaster |-> (!bsyOut && !selOut && !ioOut && !cdOut && !db6Out && !db7Out && !busy));

  // R8
  done_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bsyOut && selOut && ioOut && db7Out && !db6Out && !busy));

  // R10
  no_dual_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && noMaster));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  none_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    noMaster |=> !noMaster);
endmodule

bind scam_init_seq scam_init_seq_chk u_chk (.*);

// File: tb/sim_scam_init_seq.sv
module sim_scam_init_seq;
  localparam int DW = 8;
  localparam int FN = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          isMaster = 1'b0;
  logic [DW-1:0] deskewCnt = '0;
  logic          otherSel = 1'b0;
  logic          otherCd = 1'b0;
  logic          otherDb6 = 1'b0;
  logic          selIn, cdIn, db6In;
  logic          bsyOut, selOut, ioOut, cdOut, db6Out, db7Out;
  logic          done, noMaster, busy;

  // wired-OR bus: this device plus the bench's other devices
  assign selIn = selOut | otherSel;
  assign cdIn  = cdOut | otherCd;
  assign db6In = db6Out | otherDb6;

  scam_init_seq #(.DLY_W(DW), .FILT_N(FN)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .isMaster(isMaster),
    .deskewCnt(deskewCnt), .selIn(selIn), .cdIn(cdIn), .db6In(db6In),
    .bsyOut(bsyOut), .selOut(selOut), .ioOut(ioOut), .cdOut(cdOut),
    .db6Out(db6Out), .db7Out(db7Out), .done(done), .noMaster(noMaster),
    .busy(busy)
  );

  always #4 clk = ~clk;

  int    vecs = 0;
  int    errs = 0;
  string tag = "R1";
  logic  eBsy = 0, eSel = 0, eIo = 0, eCd = 0, eDb6 = 0, eDb7 = 0;
  logic  eDone = 0, eNoM = 0, eBusy = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic chk(input logic got, input logic exp, input string nm, input string req);
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, nm, $time, got, exp);
    end
  endtask

  // compare all outputs midway between clock edges
  always @(negedge clk) begin
    vecs++;
    chk(bsyOut,   eBsy,  "bsyOut",   tag);
    chk(selOut,   eSel,  "selOut",   tag);
    chk(ioOut,    eIo,   "ioOut",    tag);
    chk(cdOut,    eCd,   "cdOut",    tag);
    chk(db6Out,   eDb6,  "db6Out",   tag);
    chk(db7Out,   eDb7,  "db7Out",   tag);
    chk(busy,     eBusy, "busy",     tag);
    chk(done,     eDone, "done",     "R10");
    chk(noMaster, eNoM,  "noMaster", "R10");
  end

  // behavioural reference: walks the protocol with edge counts
  initial begin : refModel
    wait (rstN === 1'b1);
    forever begin
      @(posedge clk);
      eDone = 0;
      eNoM  = 0;
      if (start) begin
        int  w;
        int  quietRun;
        bit  mst;
        w   = (deskewCnt == 0) ? 1 : 2 * int'(deskewCnt);
        mst = isMaster;
        // R2 / R9: restart releases all but BSY
        tag = "R2";
        eBsy = 1; eSel = 0; eIo = 0; eCd = 0; eDb6 = 0; eDb7 = 0; eBusy = 1;
        repeat (w) @(posedge clk);
        tag = "R3";
        eSel = 1; eIo = 1; eCd = mst;
        repeat (2) @(posedge clk);
        tag = "R4";
        eDb6 = 1; eDb7 = 1;
        repeat (w) @(posedge clk);
        tag = "R5";
        eSel = 0;
        quietRun = 0;
        while (quietRun < FN) begin
          @(posedge clk);
          if (otherSel) quietRun = 0;
          else quietRun++;
        end
        tag = "R6";
        eDb6 = 0;
        @(posedge clk);
        if (!(eCd | otherCd)) begin
          tag = "R7";
          eBsy = 0; eSel = 0; eIo = 0; eCd = 0; eDb7 = 0; eBusy = 0; eNoM = 1;
        end else begin
          tag = "R8";
          quietRun = 0;
          while (quietRun < FN) begin
            @(posedge clk);
            if (otherDb6) quietRun = 0;
            else quietRun++;
          end
          eSel = 1; eDone = 1; eBusy = 0;
        end
      end else if (!eBusy && eBsy) begin
        tag = "R9";
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input int d, input logic m);
    deskewCnt = DW'(d);
    isMaster  = m;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin : stim
    // R1: reset state checked by the comparator while rstN is low
    cyc(3);
    rstN = 1'b1;
    cyc(2);

    // R3 R8: master, D=2, nobody else on the bus
    kick(2, 1'b1);
    waitIdle();
    // R9: lines held while idle after done
    cyc(5);

    // R7: slave, D=0, no master anywhere -> released
    kick(0, 1'b0);
    waitIdle();
    cyc(3);

    // R6 R8 R2: slave, D=1, other master holds C/D, SEL and DB6 glitch
    otherSel = 1'b1;
    otherCd  = 1'b1;
    otherDb6 = 1'b1;
    kick(1, 1'b0);
    cyc(2);
    deskewCnt = DW'(9);   // R2: ignored, captured at start
    isMaster  = 1'b1;
    start     = 1'b1;     // R2: start while busy ignored
    cyc(1);
    start     = 1'b0;
    cyc(12);
    otherSel = 1'b0;
    cyc(2);
    otherSel = 1'b1;      // R6: glitch restarts the count
    cyc(1);
    otherSel = 1'b0;
    cyc(12);
    otherDb6 = 1'b0;
    cyc(1);
    otherDb6 = 1'b1;      // R8: DB6 glitch
    cyc(1);
    otherDb6 = 1'b0;
    waitIdle();
    otherCd = 1'b0;
    cyc(4);

    // R4 R5 R8: master, D=3, DB6 held by another device with a glitch
    otherDb6 = 1'b1;
    kick(3, 1'b1);
    cyc(22);
    otherDb6 = 1'b0;
    cyc(2);
    otherDb6 = 1'b1;
    cyc(1);
    otherDb6 = 1'b0;
    waitIdle();

    // R9: immediate restart after done releases all but BSY
    kick(0, 1'b1);
    waitIdle();
    cyc(4);

    report();
    $finish;
  end
endmodule